// File: doc/BRIEF.md
# SPI Target with Early-Release Abort

This block is the receiving end of a four-wire serial link. It runs entirely on a fast system clock and oversamples the link clock, the controller-to-target data line and the active-low select. Every edge of the link clock is found inside the system clock domain. Each word moves in both directions at once. The target assembles the incoming bits into a received word, and it shifts out a transmit word that was loaded beforehand. The clock idle level and the capture edge can be set four ways, and the first bit on the wire can be the most or the least significant.

When the final bit of a word has been captured, a one-cycle done pulse appears together with the new received word. A controller that releases select before that point has abandoned the word. The target then discards the bits it has collected so far, clears its transmit word and raises a one-cycle abort pulse. While the target is not selected, its data output is floated.

Top module: `spi_tgt`

## Requirements
- R1: After reset, miso_oe_o, rx_done_o and abort_o are 0 and rx_word_o is all zeros.
- R2: With wide_en_i=0 a word has 8 bits. With wide_en_i=1, a wlen_code_i of 8 to 15 gives that many bits, 0 gives 16 bits, and 1 to 7 gives 8 bits.
- R3: The received word equals the bits presented on mosi_i at the capture edges. With cpol_i=0 the leading edge is the rising one; with cpol_i=1 it is the falling one. With cpha_i=0 capture happens on leading edges; with cpha_i=1 it happens on trailing edges.
- R4: The loaded transmit word appears on miso_o one bit per SCK cycle. With cpha_i=0 the first bit is valid from select onward and later bits change on trailing edges. With cpha_i=1 each bit changes on a leading edge.
- R5: With lsb_first_i=1, bit 0 moves first on both lines. With lsb_first_i=0, bit length-1 moves first. Bits of rx_word_o at and above the word length read as 0.
- R6: rx_done_o is a single-cycle pulse, issued once per completed word. rx_word_o changes only in the cycle where rx_done_o is high.
- R7: If select is released after at least one SCK edge but before the last capture edge, abort_o pulses once, rx_done_o stays low and rx_word_o keeps its previous value.
- R8: After an abort, the transmit word is all zeros until tx_load_i loads a new one.
- R9: While select is high, miso_oe_o is 0 and miso_o is 0. While the target is selected, miso_oe_o is 1.
- R10: A pulse on tx_load_i while the target is selected is ignored. A loaded word stays in place across completed transfers.
- R11: Once a word is complete, further SCK edges under the same select have no effect, and releasing select afterwards is not an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the controller |
| mosi_i | input | 1 | Serial data from the controller |
| sel_n_i | input | 1 | Active-low target select |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| lsb_first_i | input | 1 | 1: bit 0 moves first |
| wide_en_i | input | 1 | Enables the programmable word length |
| wlen_code_i | input | 4 | Word length code, see R2 |
| tx_load_i | input | 1 | Loads tx_word_i while deselected |
| tx_word_i | input | 16 | Word to transmit |
| miso_o | output | 1 | Serial data toward the controller |
| miso_oe_o | output | 1 | Output enable for miso_o; low means floated |
| rx_done_o | output | 1 | One-cycle word-complete pulse |
| rx_word_o | output | 16 | Last completely received word |
| abort_o | output | 1 | One-cycle pulse on early select release |

## Verification
The bench sweeps all four clock modes and both bit orders across 8, 9, 12 and 16 bit words, plus one undersized length code. A wrong edge choice would capture the data one bit late, and a wrong order would produce a mirrored word. The bench releases select in the middle of a word. A design without abort handling would report a partial word or keep transmitting stale data on the next transfer. The bench also sends extra clocks after a completed word and loads a new word while the target is selected. A design that overran would raise a second done pulse or a false abort, and one that accepted the mid-transfer load would corrupt the next word sent.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

  // number of bits in one word for the given length selection
  function automatic int word_len(input logic wide, input int code,
                                  input int maxw, input int minw);
    if (!wide) return minw;
    if (code == 0) return maxw;
    if (code < minw) return minw;
    return code;
  endfunction

  // bit position carried by the idx-th serial bit of a word
  function automatic int bit_pos(input logic lsb, input int len, input int idx);
    return lsb ? idx : (len - 1 - idx);
  endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic sel_n_i,
  output logic mosi_s,
  output logic sel_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic desel_ev
);
  logic [STAGES-1:0] sck_p, mosi_p, seln_p;
  logic sck_q, sel_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          sck_p <= '0; mosi_p <= '0; seln_p <= '1;
        end else begin
          sck_p <= sck_i; mosi_p <= mosi_i; seln_p <= sel_n_i;
        end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          sck_p <= '0; mosi_p <= '0; seln_p <= '1;
        end else begin
          sck_p  <= {sck_p[STAGES-2:0], sck_i};
          mosi_p <= {mosi_p[STAGES-2:0], mosi_i};
          seln_p <= {seln_p[STAGES-2:0], sel_n_i};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      sck_q <= sck_p[STAGES-1];
      sel_q <= sel_s;
    end

  assign mosi_s   = mosi_p[STAGES-1];
  assign sel_s    = ~seln_p[STAGES-1];
  assign sck_rise = sck_p[STAGES-1] & ~sck_q;
  assign sck_fall = ~sck_p[STAGES-1] & sck_q;
  assign desel_ev = sel_q & ~sel_s;
endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge (
  input  logic cpol,
  input  logic cpha,
  input  logic sck_rise,
  input  logic sck_fall,
  output logic sample_ev,
  output logic shift_ev
);
  logic lead_ev, trail_ev;

  always_comb begin
    lead_ev   = cpol ? sck_fall : sck_rise;
    trail_ev  = cpol ? sck_rise : sck_fall;
    sample_ev = cpha ? trail_ev : lead_ev;
    shift_ev  = cpha ? lead_ev : trail_ev;
  end
endmodule

// File: rtl/spi_tgt_core.sv
module spi_tgt_core
  import spi_tgt_pkg::*;
#(
  parameter int MAXW = 16,
  parameter int CW   = 4,
  parameter int IW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_s,
  input  logic            desel_ev,
  input  logic            sample_ev,
  input  logic            shift_ev,
  input  logic            mosi_s,
  input  logic            cpha,
  input  logic            lsb,
  input  logic [IW-1:0]   len,
  input  logic            tx_load,
  input  logic [MAXW-1:0] tx_word,
  output logic            miso_bit,
  output logic            rx_done,
  output logic [MAXW-1:0] rx_word,
  output logic            abort,
  output logic            fin
);
  logic [IW-1:0]   rcnt, scnt, didx;
  logic [MAXW-1:0] tx_q, rx_sr, rx_nxt;
  logic [CW-1:0]   rpos, dpos;
  logic            started, last_bit;

  always_comb begin
    rpos   = CW'(bit_pos(lsb, int'(len), int'(rcnt)));
    rx_nxt = rx_sr;
    rx_nxt[rpos] = mosi_s;
    if (cpha && scnt != '0) didx = scnt - IW'(1);
    else                    didx = scnt;
    if (didx >= len) didx = len - IW'(1);
    dpos     = CW'(bit_pos(lsb, int'(len), int'(didx)));
    miso_bit = tx_q[dpos];
    started  = (rcnt != '0) || (scnt != '0);
    last_bit = (rcnt == len - IW'(1));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rcnt <= '0; scnt <= '0; fin <= 1'b0;
      tx_q <= '0; rx_sr <= '0; rx_word <= '0;
      rx_done <= 1'b0; abort <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      abort   <= 1'b0;
      if (!sel_s) begin
        rcnt  <= '0;
        scnt  <= '0;
        fin   <= 1'b0;
        rx_sr <= '0;
        if (desel_ev && started && !fin) begin
          abort <= 1'b1;
          tx_q  <= '0;
        end else if (tx_load) begin
          tx_q <= tx_word;
        end
      end else if (!fin) begin
        if (shift_ev && scnt != len) scnt <= scnt + IW'(1);
        if (sample_ev) begin
          rx_sr <= rx_nxt;
          if (last_bit) begin
            fin     <= 1'b1;
            rx_done <= 1'b1;
            rx_word <= rx_nxt;
          end else begin
            rcnt <= rcnt + IW'(1);
          end
        end
      end
    end
endmodule

// File: rtl/spi_tgt.sv
module spi_tgt
  import spi_tgt_pkg::*;
#(
  parameter int MAXW        = 16,
  parameter int MINW        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sck_i,
  input  logic                     mosi_i,
  input  logic                     sel_n_i,
  input  logic                     cpol_i,
  input  logic                     cpha_i,
  input  logic                     lsb_first_i,
  input  logic                     wide_en_i,
  input  logic [$clog2(MAXW)-1:0]  wlen_code_i,
  input  logic                     tx_load_i,
  input  logic [MAXW-1:0]          tx_word_i,
  output logic                     miso_o,
  output logic                     miso_oe_o,
  output logic                     rx_done_o,
  output logic [MAXW-1:0]          rx_word_o,
  output logic                     abort_o
);
  localparam int CW = $clog2(MAXW);
  localparam int IW = $clog2(MAXW + 1);

  logic mosi_s, sel_s, sck_rise, sck_fall, desel_ev;
  logic sample_ev, shift_ev, miso_bit, fin;
  logic [IW-1:0] len;

  assign len = IW'(word_len(wide_en_i, int'(wlen_code_i), MAXW, MINW));

  spi_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .mosi_i(mosi_i),
    .sel_n_i(sel_n_i), .mosi_s(mosi_s), .sel_s(sel_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .desel_ev(desel_ev)
  );

  spi_tgt_edge u_edge (
    .cpol(cpol_i), .cpha(cpha_i), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sample_ev(sample_ev), .shift_ev(shift_ev)
  );

  spi_tgt_core #(.MAXW(MAXW), .CW(CW), .IW(IW)) u_core (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .desel_ev(desel_ev),
    .sample_ev(sample_ev), .shift_ev(shift_ev), .mosi_s(mosi_s),
    .cpha(cpha_i), .lsb(lsb_first_i), .len(len), .tx_load(tx_load_i),
    .tx_word(tx_word_i), .miso_bit(miso_bit), .rx_done(rx_done_o),
    .rx_word(rx_word_o), .abort(abort_o), .fin(fin)
  );

  assign miso_oe_o = sel_s;
  assign miso_o    = sel_s & miso_bit;
endmodule

// File: rtl/spi_tgt_chk.sv
module spi_tgt_chk #(
  parameter int MAXW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            miso_o,
  input logic            miso_oe_o,
  input logic            rx_done_o,
  input logic [MAXW-1:0] rx_word_o,
  input logic            abort_o,
  input logic            sample_ev,
  input logic            desel_ev,
  input logic            fin
);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_o |=> !rx_done_o);

  a_r6_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done_o |-> $stable(rx_word_o));

  a_r3_done_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_o |-> $past(sample_ev));

  a_r7_abort_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(desel_ev));

  a_r7_abort_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_o && rx_done_o));

  a_r11_no_abort_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !$past(fin));

  a_r9_quiet_when_floated: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe_o |-> !miso_o);
endmodule

bind spi_tgt spi_tgt_chk #(.MAXW(MAXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
  .rx_done_o(rx_done_o), .rx_word_o(rx_word_o), .abort_o(abort_o),
  .sample_ev(sample_ev), .desel_ev(desel_ev), .fin(fin)
);

// File: tb/sim_spi_tgt.sv
module sim_spi_tgt;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, sel_n = 1'b1;
  logic cpol = 1'b0, cpha = 1'b0, lsb = 1'b0, wide = 1'b0;
  logic [3:0] code = 4'd0;
  logic tx_load = 1'b0;
  logic [15:0] tx_word = '0;
  logic miso, miso_oe, done, abort_w;
  logic [15:0] rx_word;

  int vectors = 0, fails = 0, ndone = 0, nabort = 0;
  bit oe_low_seen = 0, finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_tgt u0 (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi), .sel_n_i(sel_n),
    .cpol_i(cpol), .cpha_i(cpha), .lsb_first_i(lsb), .wide_en_i(wide),
    .wlen_code_i(code), .tx_load_i(tx_load), .tx_word_i(tx_word),
    .miso_o(miso), .miso_oe_o(miso_oe), .rx_done_o(done),
    .rx_word_o(rx_word), .abort_o(abort_w)
  );

  always @(posedge clk) begin
    if (done) ndone++;
    if (abort_w) nabort++;
  end

  function automatic int exp_len(input logic w, input logic [3:0] c);
    if (w == 1'b0) return 8;
    case (c)
      4'd0: return 16;
      4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15: return int'(c);
      default: return 8;
    endcase
  endfunction

  function automatic logic [15:0] low_mask(input int n);
    return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // one framed transfer; nclk SCK cycles are issued, then select is released
  task automatic xfer(input logic p, input logic h, input logic l, input logic w,
                      input logic [3:0] c, input bit do_load, input logic [15:0] txw,
                      input bit mid_load, input logic [15:0] mw, input int nclk,
                      output logic [15:0] got);
    int n;
    n = exp_len(w, c);
    got = '0;
    cpol = p; cpha = h; lsb = l; wide = w; code = c;
    sck = p; sel_n = 1'b1;
    wait_clk(4);
    if (do_load) begin
      tx_word = txw; tx_load = 1'b1; wait_clk(1); tx_load = 1'b0;
    end
    wait_clk(4);
    ndone = 0; nabort = 0; oe_low_seen = 0;
    sel_n = 1'b0;
    mosi = (n > 0) ? mw[l ? 0 : n-1] : 1'b0;
    wait_clk(2 * HALF);
    for (int i = 0; i < nclk; i++) begin
      int ps;
      ps = l ? i : n - 1 - i;
      if (h == 1'b0) begin
        mosi = (i < n) ? mw[ps] : 1'b0;
        wait_clk(HALF);
        if (i < n) got[ps] = miso;
        if (!miso_oe) oe_low_seen = 1;
        sck = ~sck;
        wait_clk(HALF);
        sck = ~sck;
      end else begin
        sck = ~sck;
        mosi = (i < n) ? mw[ps] : 1'b0;
        wait_clk(HALF);
        if (i < n) got[ps] = miso;
        if (!miso_oe) oe_low_seen = 1;
        sck = ~sck;
        wait_clk(HALF);
      end
      if (mid_load && i == 1) begin
        tx_word = ~txw; tx_load = 1'b1; wait_clk(1); tx_load = 1'b0;
      end
    end
    wait_clk(2 * HALF);
    sel_n = 1'b1;
    wait_clk(8);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] seed;
    logic [15:0] got, txw, mw, keep;
    logic [3:0] codes [5];
    logic wides [5];
    int n;
    codes[0] = 4'd5; wides[0] = 1'b0;
    codes[1] = 4'd9; wides[1] = 1'b1;
    codes[2] = 4'd12; wides[2] = 1'b1;
    codes[3] = 4'd0; wides[3] = 1'b1;
    codes[4] = 4'd3; wides[4] = 1'b1;
    seed = 32'h1234_5678;

    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // R1 reset state, R9 floated while idle
    chk(miso_oe == 1'b0, "R1 oe after reset", 32'(miso_oe), 0);
    chk(done == 1'b0 && abort_w == 1'b0, "R1 pulses after reset", 32'({done, abort_w}), 0);
    chk(rx_word == 16'h0, "R1 rx_word after reset", 32'(rx_word), 0);
    chk(miso == 1'b0, "R9 miso low when idle", 32'(miso), 0);

    // R2 R3 R4 R5 R6 sweep over modes, orders and lengths
    for (int m = 0; m < 4; m++)
      for (int o = 0; o < 2; o++)
        for (int k = 0; k < 5; k++)
          for (int d = 0; d < 3; d++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            txw = seed[31:16];
            seed = seed * 32'd1103515245 + 32'd12345;
            mw = seed[31:16];
            if (d == 0) begin txw = 16'hFFFF; mw = 16'h0001; end
            n = exp_len(wides[k], codes[k]);
            xfer(m[1], m[0], o[0], wides[k], codes[k], 1, txw, 0, mw, n, got);
            chk(got == (txw & low_mask(n)), "R4/R5 miso word", 32'(got), 32'(txw & low_mask(n)));
            chk(rx_word == (mw & low_mask(n)), "R2/R3/R5 rx word", 32'(rx_word), 32'(mw & low_mask(n)));
            chk(ndone == 1 && nabort == 0, "R6 one done pulse", 32'(ndone), 1);
            chk(!oe_low_seen, "R9 oe high while selected", 32'(oe_low_seen), 0);
            chk(miso_oe == 1'b0 && miso == 1'b0, "R9 floated after release", 32'({miso_oe, miso}), 0);
          end

    // R7 early release, R8 transmit word cleared
    xfer(0, 1, 0, 1, 4'd12, 1, 16'h0ABC, 0, 16'h0123, 12, got);
    keep = rx_word;
    xfer(0, 1, 0, 1, 4'd12, 1, 16'h0F0F, 0, 16'h0FFF, 5, got);
    chk(nabort == 1, "R7 abort pulse", 32'(nabort), 1);
    chk(ndone == 0, "R7 no done on abort", 32'(ndone), 0);
    chk(rx_word == keep, "R7 rx word kept", 32'(rx_word), 32'(keep));
    xfer(0, 1, 0, 1, 4'd12, 0, 16'h0, 0, 16'h0555, 12, got);
    chk(got == 16'h0, "R8 transmit cleared after abort", 32'(got), 0);
    chk(rx_word == 16'h0555, "R8 reception after abort", 32'(rx_word), 32'h555);

    // R10 load while selected ignored, word kept for the next transfer
    xfer(1, 0, 1, 0, 4'd0, 1, 16'h00A5, 1, 16'h003C, 8, got);
    chk(got == 16'h00A5, "R10 mid-transfer load ignored", 32'(got), 32'hA5);
    xfer(1, 0, 1, 0, 4'd0, 0, 16'h0, 0, 16'h00C3, 8, got);
    chk(got == 16'h00A5, "R10 word retained", 32'(got), 32'hA5);

    // R11 surplus clocks after a complete word
    xfer(1, 1, 0, 1, 4'd9, 1, 16'h0155, 0, 16'h01AA, 12, got);
    chk(ndone == 1, "R11 single done with extra clocks", 32'(ndone), 1);
    chk(nabort == 0, "R11 no abort after complete word", 32'(nabort), 0);
    chk(rx_word == 16'h01AA, "R11 rx word from first bits", 32'(rx_word), 32'h1AA);

    finish_run();
  end
endmodule